// File: doc/BRIEF.md
# Two-Pass Booth Multiplier Pipeline

This block is a pipelined multiply unit that runs next to an integer pipeline and leaves a 64-bit product in a HI/LO register pair. A request carries two 32-bit operands (`iss_rs` is the multiplicand, `iss_rt` the multiplier), a signed flag and a hint that the multiplier fits in 16 bits. The operands arrive late in the shared execute cycle. In that same cycle the multiplier is radix-4 Booth recoded and registered into the unit.

The multiply array is only 32x16 wide. A hinted (short) operation makes one pass through it. A full 32x32 operation makes two passes on consecutive cycles. The first pass uses the low multiplier half. The second pass uses the high half with the multiplicand moved up 16 places. Between the passes the running sum stays in carry-save form. A single carry-propagate adder in the following stage resolves the product, and the stage after that writes HI/LO.

The full operation therefore costs one extra cycle of latency. It also blocks the issue port for one cycle. Integer work outside the unit keeps flowing.

Top module: `mul_twopass_unit`

## Requirements
- R1: While reset is held and right after it, HI and LO read 0, `hilo_wr` is low and `iss_ready` is low. `iss_ready` goes high within three clock edges after `rst_n` is released.
- R2: With `iss_signed`=1 and `iss_short`=0, the operands are two's complement and {HI,LO} becomes the 64-bit signed product. HI holds product bits [63:32] and LO holds bits [31:0].
- R3: With `iss_signed`=0 and `iss_short`=0, the operands are unsigned and {HI,LO} becomes the 64-bit unsigned product.
- R4: With `iss_short`=1, the multiplier is `iss_rt[15:0]`. It is sign-extended when `iss_signed`=1 and zero-extended otherwise. `iss_rt[31:16]` has no effect on the result.
- R5: A short request accepted at clock edge k drives `hilo_wr` high in the cycle after edge k+2. The new HI/LO value is visible after edge k+3.
- R6: A 32x32 request accepted at edge k drives `hilo_wr` high in the cycle after edge k+3. The new HI/LO value is visible after edge k+4.
- R7: `iss_ready` is low for exactly the one cycle that follows the acceptance of a 32x32 request, and high in every other cycle after reset.
- R8: A request presented while `iss_ready` is low is dropped. HI/LO change only at an edge that closes a cycle in which `hilo_wr` was high.
- R9: One request can be accepted per ready cycle. Every accepted request writes HI/LO exactly once, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | Multiply request present |
| iss_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| iss_short | input | 1 | 1: multiplier taken from the low 16 bits (single pass) |
| iss_rs | input | 32 | Multiplicand |
| iss_rt | input | 32 | Multiplier |
| iss_ready | output | 1 | Request is taken at the next edge when high |
| hilo_wr | output | 1 | HI/LO update at the end of this cycle |
| hi_q | output | 32 | HI register, product bits [63:32] |
| lo_q | output | 32 | LO register, product bits [31:0] |

## Verification
The assertions assume the following about the caller:
- it treats a request as taken only when `iss_valid` and `iss_ready` are both high at an edge;
- its inputs are never unknown;
- it does not rely on a request being held across a stall.

Under those assumptions the latency and ready properties follow from acceptance alone. The bench drives requests away from the clock edge and decides acceptance from its own model of the stall cycle. It holds directed corner requests across the stall, so they are taken one cycle late. It lets random requests that meet the stall fall away, which shows that they are dropped.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

  // One radix-4 Booth digit: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

endpackage

// File: rtl/mulp_booth_recoder.sv
module mulp_booth_recoder
  import mulp_pkg::*;
#(
  parameter int ND = 9
) (
  input  logic [2*ND:0]         win,
  output booth_dig_t [ND-1:0]   dig
);

  for (genvar j = 0; j < ND; j++) begin : g_dig
    logic [2:0] trip;
    logic       d_neg;
    logic       d_one;
    logic       d_two;

    assign trip  = win[2*j+2 -: 3];
    assign d_neg = trip[2] & ~(trip[1] & trip[0]);
    assign d_one = trip[1] ^ trip[0];
    assign d_two = (trip == 3'b011) | (trip == 3'b100);
    assign dig[j] = {d_neg, d_one, d_two};
  end

endmodule

// File: rtl/mulp_csa_row.sv
module mulp_csa_row #(
  parameter int PW = 64
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);

  logic [PW-1:0] maj;

  assign maj = (x & y) | (x & z) | (y & z);
  assign s   = x ^ y ^ z;
  assign c   = {maj[PW-2:0], 1'b0};

endmodule

// File: rtl/mulp_pp_array.sv
module mulp_pp_array
  import mulp_pkg::*;
#(
  parameter int PW     = 64,
  parameter int ND     = 9,
  parameter int HSHIFT = 16
) (
  input  logic [PW-1:0]        mcand,
  input  booth_dig_t [ND-1:0]  dig,
  input  logic                 upper,
  input  logic [PW-1:0]        acc_s,
  input  logic [PW-1:0]        acc_c,
  output logic [PW-1:0]        sum_o,
  output logic [PW-1:0]        carry_o
);

  localparam int NOPS = ND + 1;

  logic [PW-1:0] mshift;
  logic [PW-1:0] corr;
  logic [PW-1:0] ops   [NOPS];
  logic [PW-1:0] s_ch  [NOPS+1];
  logic [PW-1:0] c_ch  [NOPS+1];

  // Second pass: multiplicand moved up by the slice width
  assign mshift = upper ? (mcand << HSHIFT) : mcand;

  // Negative digits are formed as inverted magnitude plus a +1 at the
  // digit's base position, collected in one correction row.
  always_comb begin
    corr = '0;
    for (int k = 0; k < ND; k++) begin
      corr[2*k] = dig[k].neg;
    end
  end

  for (genvar j = 0; j < ND; j++) begin : g_pp
    logic [PW-1:0] mag;
    assign mag    = dig[j].two ? {mshift[PW-2:0], 1'b0} :
                    (dig[j].one ? mshift : '0);
    assign ops[j] = (dig[j].neg ? ~mag : mag) << (2*j);
  end

  assign ops[ND] = corr;

  assign s_ch[0] = acc_s;
  assign c_ch[0] = acc_c;

  for (genvar r = 0; r < NOPS; r++) begin : g_row
    mulp_csa_row #(.PW(PW)) u_row (
      .x (s_ch[r]),
      .y (c_ch[r]),
      .z (ops[r]),
      .s (s_ch[r+1]),
      .c (c_ch[r+1])
    );
  end

  assign sum_o   = s_ch[NOPS];
  assign carry_o = c_ch[NOPS];

endmodule

// File: rtl/mul_twopass_unit.sv
module mul_twopass_unit
  import mulp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iss_valid,
  input  logic         iss_signed,
  input  logic         iss_short,
  input  logic [W-1:0] iss_rs,
  input  logic [W-1:0] iss_rt,
  output logic         iss_ready,
  output logic         hilo_wr,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  localparam int H    = W / 2;
  localparam int ND   = H / 2 + 1;
  localparam int PW   = 2 * W;
  localparam int WINW = 2 * ND + 1;

  // ---------------- reset release synchronizer ----------------
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // ---------------- E stage: operand extension and recoding ----------------
  logic              e_a_ext;
  logic              e_lo_ext;
  logic              e_hi_ext;
  logic [PW-1:0]     e_mcand;
  logic [WINW-1:0]   e_win_lo;
  logic [WINW-1:0]   e_win_hi;
  booth_dig_t [ND-1:0] e_dig_lo;
  booth_dig_t [ND-1:0] e_dig_hi;
  logic              accept;

  assign e_a_ext  = iss_signed & iss_rs[W-1];
  assign e_mcand  = {{W{e_a_ext}}, iss_rs};
  // Low window: a short op extends per signedness; a full op repeats bit H-1
  // so the top digit of the low pass is zero and the high pass carries it.
  assign e_lo_ext = iss_short ? (iss_signed & iss_rt[H-1]) : iss_rt[H-1];
  assign e_win_lo = {e_lo_ext, e_lo_ext, iss_rt[H-1:0], 1'b0};
  assign e_hi_ext = iss_signed & iss_rt[W-1];
  assign e_win_hi = {e_hi_ext, e_hi_ext, iss_rt[W-1:H], iss_rt[H-1]};

  mulp_booth_recoder #(.ND(ND)) u_rec_lo (
    .win (e_win_lo),
    .dig (e_dig_lo)
  );

  mulp_booth_recoder #(.ND(ND)) u_rec_hi (
    .win (e_win_hi),
    .dig (e_dig_hi)
  );

  // ---------------- M stage state ----------------
  logic                m_vld;
  logic                m_long;
  logic                m_pass;
  logic [PW-1:0]       m_mcand;
  booth_dig_t [ND-1:0] m_dig_lo;
  booth_dig_t [ND-1:0] m_dig_hi;
  logic [PW-1:0]       m_acc_s;
  logic [PW-1:0]       m_acc_c;

  logic                m_loop;
  logic                m_vld_d;
  logic                m_pass_d;
  booth_dig_t [ND-1:0] m_dig_sel;
  logic [PW-1:0]       m_in_s;
  logic [PW-1:0]       m_in_c;
  logic [PW-1:0]       m_out_s;
  logic [PW-1:0]       m_out_c;

  assign m_loop    = m_vld & m_long & ~m_pass;
  assign iss_ready = rst_q_n & ~m_loop;
  assign accept    = iss_valid & iss_ready;

  always_comb begin
    m_vld_d  = accept | m_loop;
    m_pass_d = m_loop;
  end

  assign m_dig_sel = m_pass ? m_dig_hi : m_dig_lo;
  assign m_in_s    = m_pass ? m_acc_s : '0;
  assign m_in_c    = m_pass ? m_acc_c : '0;

  mulp_pp_array #(.PW(PW), .ND(ND), .HSHIFT(H)) u_array (
    .mcand   (m_mcand),
    .dig     (m_dig_sel),
    .upper   (m_pass),
    .acc_s   (m_in_s),
    .acc_c   (m_in_c),
    .sum_o   (m_out_s),
    .carry_o (m_out_c)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      m_vld  <= 1'b0;
      m_pass <= 1'b0;
    end else begin
      m_vld  <= m_vld_d;
      m_pass <= m_pass_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      m_long   <= ~iss_short;
      m_mcand  <= e_mcand;
      m_dig_lo <= e_dig_lo;
      m_dig_hi <= e_dig_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (m_loop) begin
      m_acc_s <= m_out_s;
      m_acc_c <= m_out_c;
    end
  end

  // ---------------- A stage: carry-propagate add ----------------
  logic          a_vld;
  logic          a_vld_d;
  logic [PW-1:0] a_s;
  logic [PW-1:0] a_c;
  logic [PW-1:0] a_sum;

  assign a_vld_d = m_vld & ~m_loop;
  assign a_sum   = a_s + a_c;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) a_vld <= 1'b0;
    else          a_vld <= a_vld_d;
  end

  always_ff @(posedge clk) begin
    if (a_vld_d) begin
      a_s <= m_out_s;
      a_c <= m_out_c;
    end
  end

  // ---------------- W stage: HI/LO write ----------------
  logic          w_vld;
  logic [PW-1:0] w_prod;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) w_vld <= 1'b0;
    else          w_vld <= a_vld;
  end

  always_ff @(posedge clk) begin
    if (a_vld) w_prod <= a_sum;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (w_vld) begin
      hi_q <= w_prod[PW-1:W];
      lo_q <= w_prod[W-1:0];
    end
  end

  assign hilo_wr = w_vld;

endmodule

// File: rtl/mul_twopass_unit_chk.sv
module mul_twopass_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         core_rst_n,
  input logic         iss_valid,
  input logic         iss_short,
  input logic         iss_ready,
  input logic         hilo_wr,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);

  // R1: first cycle out of reset shows a cleared HI/LO and no write
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (hi_q == '0 && lo_q == '0 && !hilo_wr));

  // R7: a full-width acceptance blocks the port for the next cycle
  assert_ready_stall_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (iss_valid && iss_ready && !iss_short) |=> !iss_ready);

  // R7: the stall never lasts longer than one cycle
  assert_ready_resume_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !iss_ready |=> iss_ready);

  // R5: short op reaches the write stage three edges after acceptance
  assert_short_latency_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (iss_valid && iss_ready && iss_short) |=> ##2 hilo_wr);

  // R6: full op reaches the write stage four edges after acceptance
  assert_long_latency_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (iss_valid && iss_ready && !iss_short) |=> ##3 hilo_wr);

  // R8: HI/LO hold whenever no write is signalled
  assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !hilo_wr |=> $stable({hi_q, lo_q}));

endmodule

bind mul_twopass_unit mul_twopass_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .core_rst_n (rst_q_n),
  .iss_valid  (iss_valid),
  .iss_short  (iss_short),
  .iss_ready  (iss_ready),
  .hilo_wr    (hilo_wr),
  .hi_q       (hi_q),
  .lo_q       (lo_q)
);

// File: tb/mul_twopass_unit_bench.sv
module mul_twopass_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic        iss_signed;
  logic        iss_short;
  logic [31:0] iss_rs;
  logic [31:0] iss_rt;
  logic        iss_ready;
  logic        hilo_wr;
  logic [31:0] hi_q;
  logic [31:0] lo_q;

  mul_twopass_unit #(.W(32)) u_mul_twopass_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_signed (iss_signed),
    .iss_short  (iss_short),
    .iss_rs     (iss_rs),
    .iss_rt     (iss_rt),
    .iss_ready  (iss_ready),
    .hilo_wr    (hilo_wr),
    .hi_q       (hi_q),
    .lo_q       (lo_q)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // scoreboard
  logic [63:0] q_val  [$];
  int          q_due  [$];
  bit          q_long [$];
  string       q_tag  [$];
  logic [63:0] cur_exp = 64'h0;
  bit          prev_long = 1'b0;
  int          n_acc = 0;
  int          n_wr  = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                           input bit sgn, input bit shrt);
    logic [31:0] bb;
    logic [63:0] p;
    bb = shrt ? (sgn ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]}) : b;
    if (sgn) p = $signed({{32{a[31]}}, a}) * $signed({{32{bb[31]}}, bb});
    else     p = {32'h0, a} * {32'h0, bb};
    return p;
  endfunction

  function automatic logic [31:0] corner(input int k);
    case (k % 5)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic logic [31:0] short_corner(input int k);
    case (k % 4)
      0: return 32'h0000_FFFF;
      1: return 32'hFFFF_8000;
      2: return 32'h1234_7FFF;   // upper half must be ignored (R4)
      default: return 32'hABCD_0000;
    endcase
  endfunction

  // Checks made with the state visible between edges
  task automatic observe();
    bit exp_wr;
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk({hi_q, lo_q} == q_val[0], q_tag[0], {hi_q, lo_q}, q_val[0]);
      cur_exp = q_val[0];
      void'(q_val.pop_front());
      void'(q_due.pop_front());
      void'(q_long.pop_front());
      void'(q_tag.pop_front());
    end else begin
      chk({hi_q, lo_q} == cur_exp, "R8 hold", {hi_q, lo_q}, cur_exp);
    end
    exp_wr = (q_due.size() > 0 && q_due[0] == cyc + 1);
    chk(hilo_wr == exp_wr, exp_wr ? (q_long[0] ? "R6 latency" : "R5 latency") : "R8 no write",
        {63'h0, hilo_wr}, {63'h0, exp_wr});
    if (hilo_wr) n_wr++;
    chk(iss_ready == !prev_long, "R7 ready", {63'h0, iss_ready}, {63'h0, !prev_long});
  endtask

  // Drive one request for the coming edge and update the model
  task automatic drive(input bit v, input logic [31:0] a, input logic [31:0] b,
                       input bit sgn, input bit shrt, output bit acc);
    string tag;
    iss_valid  = v;
    iss_rs     = a;
    iss_rt     = b;
    iss_signed = sgn;
    iss_short  = shrt;
    acc = v && !prev_long;
    if (acc) begin
      tag = shrt ? "R4 short value" : (sgn ? "R2 signed value" : "R3 unsigned value");
      q_val.push_back(ref_prod(a, b, sgn, shrt));
      q_due.push_back(cyc + 1 + (shrt ? 3 : 4));
      q_long.push_back(!shrt);
      q_tag.push_back(tag);
      n_acc++;
    end
    prev_long = acc && !shrt;
  endtask

  localparam int NDIR = 70;
  localparam int NCYC = 3000;

  initial begin
    bit          acc;
    int          dix;
    logic [31:0] a;
    logic [31:0] b;
    bit          sgn;
    bit          shrt;
    bit          v;

    void'($urandom(32'h5EED_0042));
    rst_n      = 1'b0;
    iss_valid  = 1'b0;
    iss_signed = 1'b0;
    iss_short  = 1'b0;
    iss_rs     = '0;
    iss_rt     = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({hi_q, lo_q} == 64'h0, "R1 reset HI/LO", {hi_q, lo_q}, 64'h0);
    chk(hilo_wr == 1'b0, "R1 reset write", {63'h0, hilo_wr}, 64'h0);
    chk(iss_ready == 1'b0, "R1 ready in reset", {63'h0, iss_ready}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(iss_ready == 1'b1, "R1 ready after reset", {63'h0, iss_ready}, 64'h1);
    chk({hi_q, lo_q} == 64'h0, "R1 HI/LO after reset", {hi_q, lo_q}, 64'h0);

    dix = 0;
    for (int i = 0; i < NCYC; i++) begin
      if (i > 0) @(negedge clk);
      observe();
      if (dix < NDIR) begin
        // directed corners, held across a stall until taken (R8, R9)
        v = 1'b1;
        if (dix < 50) begin
          a = corner(dix); b = corner(dix / 5); sgn = (dix >= 25); shrt = 1'b0;
        end else begin
          a = corner(dix); b = short_corner(dix / 5); sgn = dix[0]; shrt = 1'b1;
        end
        drive(v, a, b, sgn, shrt, acc);
        if (acc) dix++;
      end else begin
        v    = ($urandom % 4) != 0;
        a    = ($urandom % 8 == 0) ? corner($urandom % 5) : $urandom;
        b    = ($urandom % 8 == 0) ? corner($urandom % 5) : $urandom;
        sgn  = $urandom % 2;
        shrt = $urandom % 2;
        if (shrt && ($urandom % 2 == 0))
          b = sgn ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]};
        drive(v, a, b, sgn, shrt, acc);
      end
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      observe();
      drive(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, acc);
    end
    // R9: one write per accepted request, nothing left outstanding
    chk(n_wr == n_acc, "R9 write count", 64'(n_wr), 64'(n_acc));
    chk(q_due.size() == 0, "R9 drained", 64'(q_due.size()), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule